// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two levels of translation tables from memory and needs no software help on the success path. A request carries the virtual address, a write flag and a user-mode flag. The walk begins at the frame named by a table-base input, and that input is sampled when the request is accepted. Switching to another address space therefore only means presenting a different base frame before the next request.

The walker issues single-word reads on a valid/ready request channel and takes each word back on a one-cycle response strobe. After the second-level word arrives, it applies the per-page write and user permissions. It then reports one of two outcomes as a one-cycle pulse: the physical address, or a fault together with a cause code and the level that produced it. Only one walk is in flight at a time.

Top module: `ptw_top`

## Requirements
- R1: While reset is asserted, `req_ready` is 1 and `mem_rd_valid`, `rsp_done`, `rsp_fault`, `rsp_paddr`, `rsp_cause` and `rsp_level` are all 0.
- R2: The first read of a walk goes to `base_ppn*4096 + va[31:22]*4`, where `base_ppn` is the value sampled in the accepting cycle. A later change of `base_ppn` has no effect on a walk already running.
- R3: When the first-level word is valid, the second read goes to `word[31:12]*4096 + va[21:12]*4`. A table word holds the frame number in bits 31:12, present in bit 0, writable in bit 1 and user-accessible in bit 2.
- R4: A walk that completes without a fault raises `rsp_done` for exactly one cycle, with `rsp_paddr = {leaf[31:12], va[11:0]}` and `rsp_cause` = 0.
- R5: A first-level word with bit 0 clear ends the walk with `rsp_fault`, cause 1 (not present) and `rsp_level` 0, and no second read is made.
- R6: A second-level word with bit 0 clear gives `rsp_fault`, cause 1 and `rsp_level` 1.
- R7: A user-mode request whose leaf word has bit 2 clear gives cause 3 (privilege) at level 1. This check wins when the write check would also fail.
- R8: A write whose leaf word has bit 1 clear gives cause 2 (read-only) at level 1. This applies in supervisor mode as well.
- R9: The writable and user bits of a first-level word have no effect on the outcome.
- R10: From acceptance until the cycle in which `rsp_done` or `rsp_fault` is high, `req_ready` stays 0. `rsp_done` and `rsp_fault` are never high together. A read address held while `mem_rd_ready` is 0 stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| base_ppn | input | 20 | Frame number of the first-level table |
| mem_rd_valid | output | 1 | Table-word read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Table word returned |
| rsp_done | output | 1 | One-cycle pulse: translation succeeded |
| rsp_fault | output | 1 | One-cycle pulse: translation faulted |
| rsp_paddr | output | 32 | Physical address, valid with `rsp_done` |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 read-only, 3 privilege |
| rsp_level | output | 1 | Table level of the fault (0 first, 1 second) |

## Verification
The bench builds the walker with its default geometry: two levels of 10 index bits, a 12-bit offset and 32-bit table words. With that geometry, the all-zero and all-ones index values of both levels can be reached, and so can the top frame number 0xFFFFF. The memory model runs with several response latencies and with a read channel that stalls on two cycles in three. This exercises the hold rule on the read address and shows that the result does not depend on memory timing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RDONLY = 2'd2,
    FLT_PRIV   = 2'd3
  } flt_cause_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_FETCH,
    WS_WAIT
  } walk_state_e;

  localparam int unsigned FLAG_W    = 3;
  localparam int unsigned PTE_V_BIT = 0;
  localparam int unsigned PTE_W_BIT = 1;
  localparam int unsigned PTE_U_BIT = 2;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter  int unsigned VA_W   = 32,
  parameter  int unsigned OFF_W  = 12,
  parameter  int unsigned IDX_W  = 10,
  parameter  int unsigned LEVELS = 2,
  parameter  int unsigned PA_W   = 32,
  parameter  int unsigned PTE_W  = 32,
  localparam int unsigned PPN_W  = PA_W - OFF_W,
  localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int unsigned ENT_SH = $clog2(PTE_W / 8)
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] table_ppn,
  output logic [PA_W-1:0]  entry_addr
);

  logic [IDX_W-1:0] slice [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    localparam int unsigned LO = OFF_W + (LEVELS - 1 - g) * IDX_W;
    assign slice[g] = vaddr[LO +: IDX_W];
  end

  always_comb begin
    idx = slice[0];
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx = slice[i];
    end
  end

  assign entry_addr = (PA_W'(table_ppn) << OFF_W) + (PA_W'(idx) << ENT_SH);

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic              [FLAG_W-1:0] flags,
  input  logic                           is_leaf,
  input  logic                           is_write,
  input  logic                           is_user,
  output logic                           fault,
  output flt_cause_e                     cause
);

  always_comb begin
    cause = FLT_NONE;
    if (!flags[PTE_V_BIT])                           cause = FLT_ABSENT;
    else if (is_leaf && is_user  && !flags[PTE_U_BIT]) cause = FLT_PRIV;
    else if (is_leaf && is_write && !flags[PTE_W_BIT]) cause = FLT_RDONLY;
  end

  assign fault = (cause != FLT_NONE);

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter  int unsigned VA_W   = 32,
  parameter  int unsigned OFF_W  = 12,
  parameter  int unsigned LEVELS = 2,
  parameter  int unsigned PA_W   = 32,
  parameter  int unsigned PTE_W  = 32,
  localparam int unsigned PPN_W  = PA_W - OFF_W,
  localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [PPN_W-1:0]  base_ppn,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic [VA_W-1:0]   walk_vaddr,
  output logic [LVL_W-1:0]  walk_level,
  output logic [PPN_W-1:0]  walk_table,
  output logic              walk_leaf,
  output logic              walk_write,
  output logic              walk_user,
  input  logic              chk_fault,
  input  flt_cause_e        chk_cause,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output flt_cause_e        rsp_cause,
  output logic [LVL_W-1:0]  rsp_level
);

  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [PPN_W-1:0] table_q, table_d;
  logic [VA_W-1:0]  vaddr_q;
  logic             write_q, user_q;
  logic             done_q, done_d, fault_q, fault_d;
  flt_cause_e       cause_q, cause_d;
  logic [LVL_W-1:0] flevel_q, flevel_d;
  logic [PA_W-1:0]  paddr_q, paddr_d;
  logic             ld_req, ld_rsp;
  logic [PPN_W-1:0] pte_ppn;
  logic             unused_rsv;

  assign pte_ppn    = mem_rsp_data[PTE_W-1 -: PPN_W];
  assign unused_rsv = ^mem_rsp_data[PTE_W-PPN_W-1:FLAG_W];
  assign walk_leaf  = (level_q == LVL_W'(LEVELS - 1));

  // next-state
  always_comb begin
    state_d  = state_q;
    level_d  = level_q;
    table_d  = table_q;
    done_d   = 1'b0;
    fault_d  = 1'b0;
    cause_d  = cause_q;
    flevel_d = flevel_q;
    paddr_d  = paddr_q;
    ld_req   = 1'b0;
    ld_rsp   = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          level_d = '0;
          table_d = base_ppn;
          state_d = WS_FETCH;
        end
      end
      WS_FETCH: begin
        if (mem_rd_ready) state_d = WS_WAIT;
      end
      WS_WAIT: begin
        if (mem_rsp_valid) begin
          if (chk_fault) begin
            ld_rsp   = 1'b1;
            fault_d  = 1'b1;
            cause_d  = chk_cause;
            flevel_d = level_q;
            state_d  = WS_IDLE;
          end else if (walk_leaf) begin
            ld_rsp   = 1'b1;
            done_d   = 1'b1;
            cause_d  = FLT_NONE;
            flevel_d = level_q;
            paddr_d  = {pte_ppn, vaddr_q[OFF_W-1:0]};
            state_d  = WS_IDLE;
          end else begin
            level_d  = level_q + LVL_W'(1);
            table_d  = pte_ppn;
            state_d  = WS_FETCH;
          end
        end
      end
      default: state_d = WS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= WS_IDLE;
      level_q  <= '0;
      table_q  <= '0;
      vaddr_q  <= '0;
      write_q  <= 1'b0;
      user_q   <= 1'b0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      cause_q  <= FLT_NONE;
      flevel_q <= '0;
      paddr_q  <= '0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
      table_q <= table_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      if (ld_req) begin
        vaddr_q <= req_vaddr;
        write_q <= req_write;
        user_q  <= req_user;
      end
      if (ld_rsp) begin
        cause_q  <= cause_d;
        flevel_q <= flevel_d;
        paddr_q  <= paddr_d;
      end
    end
  end

  assign req_ready    = (state_q == WS_IDLE);
  assign mem_rd_valid = (state_q == WS_FETCH);
  assign walk_vaddr   = vaddr_q;
  assign walk_level   = level_q;
  assign walk_table   = table_q;
  assign walk_write   = write_q;
  assign walk_user    = user_q;
  assign rsp_done     = done_q;
  assign rsp_fault    = fault_q;
  assign rsp_paddr    = paddr_q;
  assign rsp_cause    = cause_q;
  assign rsp_level    = flevel_q;

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready) |=> !req_ready);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rsp_done && rsp_fault));
  p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_done || rsp_fault) |-> req_ready);
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_done |=> !rsp_done);
  p_done_clean_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_done |-> (rsp_cause == FLT_NONE));

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter  int unsigned VA_W        = 32,
  parameter  int unsigned OFF_W       = 12,
  parameter  int unsigned IDX_W       = 10,
  parameter  int unsigned LEVELS      = 2,
  parameter  int unsigned PA_W        = 32,
  parameter  int unsigned PTE_W       = 32,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned PPN_W       = PA_W - OFF_W,
  localparam int unsigned LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [PPN_W-1:0] base_ppn,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_done,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_cause,
  output logic [LVL_W-1:0] rsp_level
);

  logic             rst_ni;
  logic [VA_W-1:0]  walk_vaddr;
  logic [LVL_W-1:0] walk_level;
  logic [PPN_W-1:0] walk_table;
  logic             walk_leaf, walk_write, walk_user;
  logic             chk_fault;
  flt_cause_e       chk_cause, cause_out;

  ptw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  ptw_addr_gen #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .PA_W(PA_W), .PTE_W(PTE_W)
  ) u_addr (
    .vaddr      (walk_vaddr),
    .level      (walk_level),
    .table_ppn  (walk_table),
    .entry_addr (mem_rd_addr)
  );

  ptw_pte_check u_chk (
    .flags    (mem_rsp_data[FLAG_W-1:0]),
    .is_leaf  (walk_leaf),
    .is_write (walk_write),
    .is_user  (walk_user),
    .fault    (chk_fault),
    .cause    (chk_cause)
  );

  ptw_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .LEVELS(LEVELS), .PA_W(PA_W), .PTE_W(PTE_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .req_user      (req_user),
    .base_ppn      (base_ppn),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .walk_vaddr    (walk_vaddr),
    .walk_level    (walk_level),
    .walk_table    (walk_table),
    .walk_leaf     (walk_leaf),
    .walk_write    (walk_write),
    .walk_user     (walk_user),
    .chk_fault     (chk_fault),
    .chk_cause     (chk_cause),
    .rsp_done      (rsp_done),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_cause     (cause_out),
    .rsp_level     (rsp_level)
  );

  assign rsp_cause = cause_out;

  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  p_absent_l0_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_fault && rsp_level == '0) |-> (rsp_cause == 2'd1));

endmodule

// File: tb/tb_ptw_top.sv
module tb_ptw_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] base_ppn = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic [0:0]  rsp_level;

  always #5 clk = ~clk;

  ptw_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .base_ppn(base_ppn), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause), .rsp_level(rsp_level)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] pmem [logic [31:0]];
  logic [31:0] exp_rd_q [$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] pte(input logic [19:0] fr, input bit v,
                                     input bit w, input bit u);
    return {fr, 9'h0, u, w, v};
  endfunction

  function automatic void put(input logic [19:0] tbl, input int idx, input logic [31:0] w);
    pmem[{tbl, 12'h0} + 32'(idx) * 4] = w;
  endfunction

  // memory model: accepts reads, answers after lat_cfg extra cycles
  int cyc = 0, lat_cfg = 0, stall_mode = 0, lat_cnt = 0;
  bit pend = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      pend = 0;
      mem_rd_ready = 1'b0;
    end else begin
      if (pend) begin
        if (lat_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend_addr);
          pend = 0;
        end else lat_cnt--;
      end
      mem_rd_ready = (stall_mode == 0) || (cyc % 3 == 0);
      if (mem_rd_valid && mem_rd_ready) begin
        if (exp_rd_q.size() == 0) check("R5 R3", "unexpected table read", mem_rd_addr, 32'hxxxxxxxx);
        else check("R2 R3", "table read address", mem_rd_addr, exp_rd_q.pop_front());
        pend = 1; lat_cnt = lat_cfg; pend_addr = mem_rd_addr;
      end
    end
  end

  // busy model for R10
  bit busy_m = 0;
  always @(posedge clk) begin
    if (!rst_n) busy_m <= 0;
    else if (req_valid && req_ready) busy_m <= 1;
    else if (rsp_done || rsp_fault) busy_m <= 0;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10", "req_ready vs walk in flight", {31'h0, req_ready},
            {31'h0, (!busy_m || rsp_done || rsp_fault)});
      check("R10", "done and fault together", {31'h0, rsp_done && rsp_fault}, 32'h0);
    end
  end

  function automatic void ref_walk(input logic [31:0] va, input bit wr, input bit us,
                                   input logic [19:0] base, output bit f,
                                   output logic [1:0] cause, output bit lvl,
                                   output logic [31:0] pa);
    logic [31:0] a, p1, p2;
    f = 0; cause = 0; lvl = 0; pa = 0;
    a = {base, 12'h0} + {20'h0, va[31:22], 2'b00};
    exp_rd_q.push_back(a);
    p1 = rd(a);
    if (!p1[0]) begin f = 1; cause = 1; lvl = 0; return; end
    a = {p1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
    exp_rd_q.push_back(a);
    p2 = rd(a);
    lvl = 1;
    if (!p2[0])             begin f = 1; cause = 1; end
    else if (us && !p2[2])  begin f = 1; cause = 3; end
    else if (wr && !p2[1])  begin f = 1; cause = 2; end
    else pa = {p2[31:12], va[11:0]};
  endfunction

  task automatic walk(input string req, input logic [31:0] va, input bit wr,
                      input bit us, input bit hold = 0, input bit swap = 0);
    bit ef, el; logic [1:0] ec; logic [31:0] ep; int wd;
    logic [19:0] saved;
    ref_walk(va, wr, us, base_ppn, ef, ec, el, ep);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    saved = base_ppn;
    if (hold) req_vaddr = ~va; else req_valid = 1'b0;
    if (swap) base_ppn = ~base_ppn;
    wd = 0;
    while (!(rsp_done || rsp_fault) && wd < 300) begin @(negedge clk); wd++; end
    req_valid = 1'b0;
    base_ppn = saved;
    check(req, "outcome {fault,done}", {30'h0, rsp_fault, rsp_done}, ef ? 32'h2 : 32'h1);
    if (ef) begin
      check(req, "fault cause", {30'h0, rsp_cause}, {30'h0, ec});
      check(req, "fault level", {31'h0, rsp_level}, {31'h0, el});
    end else begin
      check(req, "physical address", rsp_paddr, ep);
      check(req, "cause on success", {30'h0, rsp_cause}, 32'h0);
    end
    check(req, "reads left unissued", exp_rd_q.size(), 0);
    exp_rd_q.delete();
    @(negedge clk);
    check("R4", "single-cycle result pulse", {30'h0, rsp_fault, rsp_done}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  localparam logic [19:0] B0 = 20'h00100, B1 = 20'h00400;
  localparam logic [19:0] T1 = 20'h00200, T2 = 20'h00300, T3 = 20'h00500;

  initial begin
    // tables
    put(B0, 1, pte(T1, 1, 0, 0));            // R9: W/U clear at level one
    put(B0, 2, pte(T1, 0, 1, 1));            // not present
    put(B0, 0, pte(T2, 1, 1, 1));
    put(B0, 1023, pte(T2, 1, 0, 0));
    put(T1, 2, pte(20'hABCDE, 1, 1, 1));
    put(T1, 3, pte(20'h12345, 1, 0, 1));
    put(T1, 4, pte(20'h55555, 1, 1, 0));
    put(T1, 5, pte(20'h0F0F0, 1, 0, 0));
    put(T1, 6, pte(20'h99999, 0, 1, 1));
    put(T2, 0, pte(20'h00001, 1, 0, 1));
    put(T2, 1023, pte(20'hFFFFF, 1, 1, 1));
    put(B1, 1, pte(T3, 1, 1, 1));
    put(T3, 2, pte(20'h77777, 1, 1, 1));

    repeat (3) @(negedge clk);
    check("R1", "req_ready in reset", {31'h0, req_ready}, 32'h1);
    check("R1", "mem_rd_valid in reset", {31'h0, mem_rd_valid}, 32'h0);
    check("R1", "done/fault in reset", {30'h0, rsp_fault, rsp_done}, 32'h0);
    check("R1", "paddr in reset", rsp_paddr, 32'h0);
    check("R1", "cause/level in reset", {29'h0, rsp_cause, rsp_level}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    base_ppn = B0;
    walk("R4 R9", {10'd1, 10'd2, 12'h234}, 1, 1);
    walk("R4", {10'd1, 10'd3, 12'h010}, 0, 1);
    walk("R8", {10'd1, 10'd3, 12'h010}, 1, 1);
    walk("R4", {10'd1, 10'd4, 12'hFFC}, 1, 0);
    walk("R7", {10'd1, 10'd4, 12'h000}, 0, 1);
    walk("R7", {10'd1, 10'd5, 12'h444}, 1, 1);
    walk("R8", {10'd1, 10'd5, 12'h444}, 1, 0);
    walk("R4", {10'd1, 10'd5, 12'h444}, 0, 0);
    walk("R5", {10'd2, 10'd0, 12'h000}, 0, 0);
    walk("R5", {10'd7, 10'd9, 12'h123}, 1, 1);
    walk("R6", {10'd1, 10'd6, 12'h321}, 0, 0);
    walk("R3", 32'hFFFFFFFF, 1, 1);
    walk("R3", 32'h00000000, 0, 1);

    lat_cfg = 3; stall_mode = 1;
    walk("R4", {10'd1, 10'd2, 12'hABC}, 0, 0);
    walk("R6", {10'd1, 10'd6, 12'h000}, 1, 0);
    walk("R2", {10'd1, 10'd2, 12'h234}, 0, 0, 0, 1);
    walk("R10", {10'd1, 10'd3, 12'h555}, 0, 0, 1, 0);

    lat_cfg = 1; stall_mode = 0;
    base_ppn = B1;
    walk("R2", {10'd1, 10'd2, 12'h234}, 1, 1);
    walk("R5", {10'd0, 10'd2, 12'h234}, 0, 0);
    base_ppn = B0;
    walk("R2", {10'd1, 10'd2, 12'h234}, 1, 1);
    walk("R10", 32'hFFFFF000, 1, 0, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule